// File: doc/BRIEF.md
# Serial Command Word Receiver

This block is the serial front end of a control interface. A host sends fixed 20-bit words over a four-wire serial link. The block samples the incoming data line on every rising edge of the serial clock while the active-low select is held low. Bits are assembled most significant first. The first four bits form a command code, the next eight an address, and the last eight a data byte.

The serial clock keeps running after select is released. The block uses the first four rising edges with select high to check and decode the word. On the fourth of those cycles it raises a one-cycle strobe, and the decoded fields sit beside the strobe. A frame that did not hold exactly 20 bits is dropped.

For read commands, the block exposes the received address to a neighbouring register file. It then shifts the returned byte back out on the serial output while the data byte of the frame is still coming in.

Top module: `spi_cmd_receiver`

## Requirements
- R1: A synchronous active-low reset clears the held fields to zero and holds the strobe and the serial output low.
- R2: Bits are taken MSB first on rising clock edges while sel_n is low. In the received word, bits 19:16 are the command code, bits 15:8 the address and bits 7:0 the data byte, and they appear on cmd_code, cmd_addr and cmd_data.
- R3: cmd_stb is high for exactly one clock cycle after an accepted frame. Counting the rising edges that see sel_n high as E0, E1, E2 and so on, the strobe is visible between E3 and E4 and low again after E4.
- R4: A frame in which sel_n rises after any number of bits other than 20, fewer or more, gives no strobe and leaves the held fields unchanged.
- R5: The held fields keep the last accepted word until the next accepted word, and they are stable while cmd_stb is high.
- R6: The command code 4'hA marks a read. After the 12th edge, rd_addr carries the address byte. The byte on rd_data at the 13th edge is driven on miso MSB first: bit 7 after the 13th edge, down to bit 0 after the 20th edge.
- R7: miso is low while sel_n is high, before the 13th edge of any frame, and throughout every non-read frame.
- R8: A reset asserted partway through a frame drops that frame, and no strobe follows it.
- R9: A new frame may begin on the fifth edge with sel_n high (E4). Both that frame and the one before it are accepted and strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low frame select from the host |
| mosi | input | 1 | Serial data from the host, MSB first |
| miso | output | 1 | Serial read-back data to the host, changes on rising edge |
| rd_addr | output | 8 | Address byte of the frame in progress, valid after the 12th edge |
| rd_data | input | 8 | Byte returned by the register file for rd_addr |
| cmd_stb | output | 1 | One-cycle pulse marking a decoded word |
| cmd_code | output | 4 | Command code of the last accepted word |
| cmd_addr | output | 8 | Address of the last accepted word |
| cmd_data | output | 8 | Data byte of the last accepted word |

## Verification
The bench builds the block with its default parameters: a 4-bit command, 8-bit address and data, and a 4-cycle decode window. Each frame is therefore short enough that under-length, over-length, exact-length and back-to-back frames all fit in one vector table. The 12-bit header boundary, where read-back begins, falls inside every full frame, so each read vector checks all eight returned bits against a register model in the bench. With the window at its default of 4, the assertion that ties the strobe back to the select edge is also active.

// File: rtl/spi_cmd_pkg.sv
// Shared field widths and codes for the serial command word receiver.
// Assumes a word made of command, address and data fields, sent MSB first.
package spi_cmd_pkg;
    localparam int CMD_W    = 4;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int WORD_W   = CMD_W + ADDR_W + DATA_W;
    localparam int POST_CYC = 4;
    localparam logic [CMD_W-1:0] READ_CODE = 4'hA;
endpackage

// File: rtl/cmd_shift_in.sv
// Input shifter: assembles serial bits MSB first and counts them while the
// select is low. The count saturates one above the word length so that an
// over-long frame stays distinguishable. Select high clears the count.
module cmd_shift_in #(
    parameter int WORD_W = 20,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              mosi,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(WORD_W + 1);

    // Shift in one bit per selected edge and track how many arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            cnt  <= '0;
        end else if (!sel_n) begin
            word <= {word[WORD_W-2:0], mosi};
            if (cnt != CAP) cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/cmd_post_window.sv
// Decode window: on the first edge with select high, accepts the word only
// if exactly WORD_W bits arrived. It then counts POST_CYC cycles and pulses
// the strobe on the last one. Assumes the clock keeps running after select
// rises and that POST_CYC >= 2.
module cmd_post_window #(
    parameter int WORD_W   = 20,
    parameter int CNT_W    = 5,
    parameter int POST_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  cnt,
    output logic [WORD_W-1:0] word_q,
    output logic              stb
);
    localparam int WIN_W = $clog2(POST_CYC + 1);
    localparam logic [WIN_W-1:0] LAST = WIN_W'(POST_CYC - 1);

    logic             sel_q;
    logic [WIN_W-1:0] win;
    logic             accept;

    // First high edge after a frame, with a full-length count.
    assign accept = sel_n && !sel_q && (cnt == CNT_W'(WORD_W));

    // Track select, latch the accepted word, run the window and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b1;
            win    <= '0;
            stb    <= 1'b0;
            word_q <= '0;
        end else begin
            sel_q <= sel_n;
            stb   <= (win == LAST);
            if (accept) begin
                word_q <= word;
                win    <= WIN_W'(1);
            end else if (win != '0) begin
                win <= (win == LAST) ? '0 : win + 1'b1;
            end
        end
    end

    // R3
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);
endmodule

// File: rtl/cmd_readback.sv
// Read-back path: once the command and address fields are in, and the
// command is the read code, loads the byte returned for the address. It
// then shifts that byte out MSB first on the following edges. The output
// is low whenever select is high or no read is active.
module cmd_readback #(
    parameter int               CMD_W     = 4,
    parameter int               ADDR_W    = 8,
    parameter int               DATA_W    = 8,
    parameter int               WORD_W    = 20,
    parameter int               CNT_W     = 5,
    parameter logic [CMD_W-1:0] READ_CODE = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic [WORD_W-1:0] word,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              miso
);
    localparam int HDR_W = CMD_W + ADDR_W;

    logic [DATA_W-1:0] sr;
    logic              act;
    logic              start;

    assign rd_addr = word[ADDR_W-1:0];
    assign start   = !sel_n && (cnt == CNT_W'(HDR_W))
                     && (word[HDR_W-1 -: CMD_W] == READ_CODE);

    // Load the returned byte at the header boundary, then shift it left.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_n) begin
            sr  <= '0;
            act <= 1'b0;
        end else if (start) begin
            sr  <= rd_data;
            act <= 1'b1;
        end else if (act) begin
            sr <= {sr[DATA_W-2:0], 1'b0};
        end
    end

    assign miso = act && !sel_n && sr[DATA_W-1];
endmodule

// File: rtl/spi_cmd_receiver.sv
// Top of the serial command word receiver: ties the input shifter, the
// decode window and the read-back path together, and splits the accepted
// word into its command, address and data fields. The clock is the serial
// clock itself; the reset is synchronous to it.
module spi_cmd_receiver
    import spi_cmd_pkg::*;
#(
    parameter int CMD_W_P    = CMD_W,
    parameter int ADDR_W_P   = ADDR_W,
    parameter int DATA_W_P   = DATA_W,
    parameter int POST_CYC_P = POST_CYC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_n,
    input  logic                mosi,
    output logic                miso,
    output logic [ADDR_W_P-1:0] rd_addr,
    input  logic [DATA_W_P-1:0] rd_data,
    output logic                cmd_stb,
    output logic [CMD_W_P-1:0]  cmd_code,
    output logic [ADDR_W_P-1:0] cmd_addr,
    output logic [DATA_W_P-1:0] cmd_data
);
    localparam int W_W   = CMD_W_P + ADDR_W_P + DATA_W_P;
    localparam int C_W   = $clog2(W_W + 2);
    localparam int HDR_W = CMD_W_P + ADDR_W_P;

    logic [W_W-1:0] word;
    logic [W_W-1:0] word_q;
    logic [C_W-1:0] cnt;

    cmd_shift_in #(.WORD_W(W_W), .CNT_W(C_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .mosi(mosi),
        .word(word), .cnt(cnt)
    );

    cmd_post_window #(.WORD_W(W_W), .CNT_W(C_W), .POST_CYC(POST_CYC_P)) u_win (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .word(word), .cnt(cnt),
        .word_q(word_q), .stb(cmd_stb)
    );

    cmd_readback #(
        .CMD_W(CMD_W_P), .ADDR_W(ADDR_W_P), .DATA_W(DATA_W_P),
        .WORD_W(W_W), .CNT_W(C_W), .READ_CODE(CMD_W_P'(READ_CODE))
    ) u_rb (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .word(word), .cnt(cnt),
        .rd_data(rd_data), .rd_addr(rd_addr), .miso(miso)
    );

    // Field split of the held word.
    assign cmd_code = word_q[W_W-1 -: CMD_W_P];
    assign cmd_addr = word_q[DATA_W_P +: ADDR_W_P];
    assign cmd_data = word_q[DATA_W_P-1:0];

    // R5
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> ($stable(cmd_code) && $stable(cmd_addr) && $stable(cmd_data)));

    // R7
    miso_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miso |-> (cnt > C_W'(HDR_W)));

    generate
        if (POST_CYC_P == 4) begin : g_gap
            // R3
            strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cmd_stb |-> $past(sel_n, 4));
        end
    endgenerate
endmodule

// File: tb/test_spi_cmd_receiver.sv
module test_spi_cmd_receiver;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_n;
    logic       mosi;
    logic       miso;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       cmd_stb;
    logic [3:0] cmd_code;
    logic [7:0] cmd_addr;
    logic [7:0] cmd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [19:0] exp_word;

    always #10 clk = ~clk;

    // Register file model for read-back.
    assign rd_data = rd_addr ^ 8'hC3;

    spi_cmd_receiver i_spi_cmd_receiver (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .mosi(mosi), .miso(miso),
        .rd_addr(rd_addr), .rd_data(rd_data), .cmd_stb(cmd_stb),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    // Vector: {bit count, word}
    localparam int NV = 9;
    localparam logic [25:0] VEC [NV] = '{
        {6'd20, 20'h2157E},
        {6'd20, 20'hA3C00},
        {6'd12, 20'h400A0},
        {6'd20, 20'h3002C},
        {6'd22, 20'h1F0F0},
        {6'd20, 20'hA8155},
        {6'd1,  20'h80000},
        {6'd20, 20'h80000},
        {6'd19, 20'h6ABCD}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Caller stands at a negedge. Drives nbits bits; checks miso after each edge.
    task automatic send(input int nbits, input logic [19:0] w);
        bit         is_rd  = (w[19:16] == 4'hA) && (nbits >= 20);
        logic [7:0] rd_exp = w[15:8] ^ 8'hC3;
        for (int i = 0; i < nbits; i++) begin
            sel_n = 1'b0;
            mosi  = (i < 20) ? w[19-i] : 1'b0;
            @(negedge clk);
            begin
                int   j = i + 1;
                logic e = (is_rd && j >= 13 && j <= 20) ? rd_exp[20-j] : 1'b0;
                check(miso === e, is_rd ? "R6" : "R7", miso, e);
                if (j == 12 && is_rd) check(rd_addr === w[15:8], "R6", rd_addr, w[15:8]);
            end
        end
        sel_n = 1'b1;
        mosi  = 1'b0;
    endtask

    // Observe n edges with select high; strobe expected after the 4th.
    task automatic post(input int n, input bit acc, input string req);
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            check(cmd_stb === (acc && k == 4), req, cmd_stb, (acc && k == 4));
            check(miso === 1'b0, "R7", miso, 0);
        end
    endtask

    task automatic check_fields(input string req);
        check({cmd_code, cmd_addr, cmd_data} === exp_word, req,
              {cmd_code, cmd_addr, cmd_data}, exp_word);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sel_n = 1'b1; mosi = 1'b0; exp_word = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cmd_stb === 1'b0, "R1", cmd_stb, 0);
        check(miso === 1'b0, "R1", miso, 0);
        check_fields("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: R2 field split, R3 strobe, R4 discard, R5 hold, R6 read
        for (int v = 0; v < NV; v++) begin
            int          nb  = int'(VEC[v][25:20]);
            logic [19:0] w   = VEC[v][19:0];
            bit          acc = (nb == 20);
            send(nb, w);
            post(5, acc, acc ? "R3" : "R4");
            if (acc) exp_word = w;
            check_fields(acc ? "R2" : "R5");
            @(negedge clk);
        end

        // R9 back-to-back frames with four idle edges
        send(20, 20'h5AA11);
        post(4, 1'b1, "R9");
        exp_word = 20'h5AA11;
        check_fields("R9");
        send(20, 20'hA7E22);
        post(5, 1'b1, "R9");
        exp_word = 20'hA7E22;
        check_fields("R9");

        // R8 reset in mid-frame
        @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            sel_n = 1'b0; mosi = i[0];
            @(negedge clk);
        end
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; sel_n = 1'b1;
        exp_word = '0;
        post(5, 1'b0, "R8");
        check_fields("R8");

        // R2 full frame after the mid-frame reset
        send(20, 20'hF00FF);
        post(5, 1'b1, "R2");
        exp_word = 20'hF00FF;
        check_fields("R2");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule